// File: doc/BRIEF.md
# Trigger-Qualified Up/Down Timer Counter

This block is a counter that always runs from the internal clock. An external trigger input controls when it may count. A 3-bit slave-mode code picks one of three ways the trigger is used. In free-running mode the trigger is ignored. In gated mode the counter runs only while the trigger is high. In start-triggered mode a rising trigger edge launches counting, and counting then continues until software stops it. The trigger is never used as a count clock.

Software reaches the block through a simple register port. It has a write strobe, a write address and write data, and a separate combinational read address and read data. Through this port software programs the mode, a direction bit, a global enable bit, the reload value and the live count, and it can read all of them back. When the count wraps, the block raises a one-cycle update pulse. The trigger is asynchronous to the clock and passes through a two-flop synchronizer inside the block.

Top module: `trig_timer_top`

## Requirements
- R1: After synchronous reset the count reads 0, the control register reads 0, the reload register reads all ones, and `upd_o` is low.
- R2: The control register sits at address 0. Bit 0 is the enable bit, bit 1 is the direction bit, and bits [6:4] hold the slave-mode code. Mode codes 0 (free-running), 5 (gated) and 6 (start-triggered) are stored, and reading the register returns exactly the code written.
- R3: A control write whose mode code is not 0, 5 or 6 leaves the stored mode unchanged.
- R4: When the enable bit is 0, the count holds in every mode.
- R5: In free-running mode with the enable bit set, the count changes by one on every clock edge, whatever the trigger does.
- R6: In gated mode with the enable bit set, the count advances only while the synchronized trigger is high. The first advance lands on the third clock edge after the trigger rises, and counting stops after the second edge following its fall.
- R7: In start-triggered mode, a synchronized rising trigger edge sets the enable bit, and software can read that bit back. The first advance lands on the fourth edge after the trigger rises. Counting continues after the trigger falls, and later rising edges have no effect. Clearing the enable bit stops the count.
- R8: Direction bit 0 counts up and direction bit 1 counts down.
- R9: Counting up, the count wraps from the reload value to 0. Counting down, it wraps from 0 to the reload value. Each wrap raises `upd_o` for exactly the one cycle after the wrapping edge.
- R10: A write to address 1 sets the reload value. A write to address 2 presets the count, and this load takes priority over counting. Both registers read back at the same addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal count clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 reload, 2 count) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 16 | Combinational read data |
| trig_in | input | 1 | Asynchronous trigger input |
| upd_o | output | 1 | One-cycle pulse on each wrap |

## Verification
A register write takes effect at the edge that samples the strobe. Counting under a new enable starts one edge later. A trigger change reaches the gating logic after two edges, so in gated mode the count moves on the third edge. In start-triggered mode one more edge is needed to set the enable bit, so the count moves on the fourth. The bench drives inputs and samples `rd_data` and `upd_o` only on falling edges. It counts the rising edges between a stimulus and each check, so every expected count is an exact number of edges. This also covers the two extra increments that follow the trigger's fall in gated mode, and the single-cycle window in which the update pulse is visible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        MODE_FREE  = 3'd0,
        MODE_GATED = 3'd5,
        MODE_TRIG  = 3'd6
    } slave_mode_e;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_DIR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;
    localparam int CTRL_MODE_W   = 3;
    localparam int CTRL_USED_W   = CTRL_MODE_LSB + CTRL_MODE_W;

    typedef struct packed {
        slave_mode_e mode;
        logic        dir;
        logic        en;
    } ctrl_t;

    function automatic logic mode_is_legal(input logic [CTRL_MODE_W-1:0] code);
        return (code == MODE_FREE) || (code == MODE_GATED) || (code == MODE_TRIG);
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= trig_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], trig_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             hw_start_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] reload_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic             ctrl_wr;
    logic [CTRL_MODE_W-1:0] new_mode;

    assign ctrl_wr  = wr_en && (wr_addr == REG_CTRL);
    assign new_mode = wr_data[CTRL_MODE_LSB +: CTRL_MODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '{mode: MODE_FREE, dir: 1'b0, en: 1'b0};
            reload_q <= '1;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.en  <= wr_data[CTRL_EN_BIT];
                ctrl_q.dir <= wr_data[CTRL_DIR_BIT];
                if (mode_is_legal(new_mode))
                    ctrl_q.mode <= slave_mode_e'(new_mode);
            end else if (hw_start_i && ctrl_q.mode == MODE_TRIG) begin
                ctrl_q.en <= 1'b1;
            end
            if (wr_en && wr_addr == REG_RELOAD)
                reload_q <= wr_data;
        end
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;

    assert_bad_mode_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !mode_is_legal(new_mode)) |=> $stable(ctrl_q.mode));

    assert_hw_start_sets_en_R7: assert property (@(posedge clk) disable iff (rst)
        (hw_start_i && ctrl_q.mode == MODE_TRIG && !ctrl_wr) |=> ctrl_q.en);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             dir_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             upd_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (load_i) begin
                cnt_q <= load_val_i;
            end else if (run_i) begin
                if (!dir_i) begin
                    if (cnt_q == reload_i) begin
                        cnt_q <= '0;
                        upd_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        cnt_q <= reload_i;
                        upd_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
        end
    end

    assign count_o = cnt_q;
    assign upd_o   = upd_q;

    assert_wrap_target_R9: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> (cnt_q == ($past(dir_i) ? $past(reload_i) : '0)));

endmodule

// File: rtl/trig_timer_top.sv
module trig_timer_top
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             trig_in,
    output logic             upd_o
);
    localparam int PAD_W = CNT_W - CTRL_USED_W;

    logic             trig_lvl, trig_rise;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, count;
    logic             run, load;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .trig_i(trig_in),
        .level_o(trig_lvl), .rise_o(trig_rise)
    );

    tmr_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hw_start_i(trig_rise),
        .ctrl_o(ctrl), .reload_o(reload)
    );

    assign run  = ctrl.en && ((ctrl.mode != MODE_GATED) || trig_lvl);
    assign load = wr_en && (wr_addr == REG_COUNT);

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .run_i(run), .dir_i(ctrl.dir),
        .load_i(load), .load_val_i(wr_data), .reload_i(reload),
        .count_o(count), .upd_o(upd_o)
    );

    always_comb begin
        case (rd_addr)
            REG_CTRL:   rd_data = {{PAD_W{1'b0}}, ctrl.mode, 2'b00, ctrl.dir, ctrl.en};
            REG_RELOAD: rd_data = reload;
            REG_COUNT:  rd_data = count;
            default:    rd_data = '0;
        endcase
    end

    assert_disabled_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !load) |=> $stable(count));

    assert_gate_low_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_GATED && !trig_lvl && !load) |=> $stable(count));

endmodule

// File: tb/trig_timer_top_tb_top.sv
`timescale 1ns/1ps
module trig_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        trig_in = 1'b0;
    logic        upd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    trig_timer_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_in(trig_in), .upd_o(upd_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    function automatic logic [15:0] ctl(input int mode, input bit dir, input bit en);
        return 16'((mode << 4) | (int'(dir) << 1) | int'(en));
    endfunction

    task automatic t_reset();
        int v;
        rd(2'd2, v); check("R1 count", v, 0);
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 reload", v, 16'hFFFF);
        check("R1 upd", int'(upd_o), 0);
    endtask

    task automatic t_modes();
        int v;
        wr(2'd0, ctl(5, 0, 0)); rd(2'd0, v); check("R2 mode5", v, 16'h50);
        wr(2'd0, ctl(3, 0, 0)); rd(2'd0, v); check("R3 code3", v, 16'h50);
        wr(2'd0, ctl(7, 0, 0)); rd(2'd0, v); check("R3 code7", v, 16'h50);
        wr(2'd0, ctl(6, 0, 0)); rd(2'd0, v); check("R2 mode6", v, 16'h60);
        wr(2'd0, ctl(0, 1, 0)); rd(2'd0, v); check("R2 mode0", v, 16'h02);
        wr(2'd1, 16'd1234);     rd(2'd1, v); check("R10 reload", v, 1234);
    endtask

    task automatic t_free();
        int v;
        wr(2'd0, ctl(0, 0, 0));
        wr(2'd2, 16'd10);
        wr(2'd1, 16'd100);
        cyc(3); rd(2'd2, v); check("R4 disabled hold", v, 10);
        wr(2'd0, ctl(0, 0, 1));
        rd(2'd2, v); check("R10 preset", v, 10);
        trig_in = 1'b1; cyc(2); trig_in = 1'b0; cyc(3);
        rd(2'd2, v); check("R5 free run", v, 15);
        wr(2'd0, ctl(0, 1, 1));
        cyc(4); rd(2'd2, v); check("R8 down", v, 12);
    endtask

    task automatic t_gated();
        int v;
        wr(2'd0, ctl(5, 0, 0));
        wr(2'd2, 16'd0);
        wr(2'd1, 16'd1000);
        wr(2'd0, ctl(5, 0, 1));
        cyc(4); rd(2'd2, v); check("R6 low hold", v, 0);
        trig_in = 1'b1;
        cyc(2); rd(2'd2, v); check("R6 not yet", v, 0);
        cyc(1); rd(2'd2, v); check("R6 first step", v, 1);
        cyc(5); rd(2'd2, v); check("R6 running", v, 6);
        trig_in = 1'b0;
        cyc(5); rd(2'd2, v); check("R6 stop after fall", v, 8);
    endtask

    task automatic t_trig();
        int v;
        wr(2'd0, ctl(6, 0, 0));
        wr(2'd2, 16'd0);
        cyc(3); rd(2'd2, v); check("R7 idle", v, 0);
        trig_in = 1'b1;
        cyc(3); rd(2'd2, v); check("R7 not yet", v, 0);
        rd(2'd0, v); check("R7 en set", v, 16'h61);
        cyc(1); rd(2'd2, v); check("R7 first step", v, 1);
        trig_in = 1'b0;
        cyc(5); rd(2'd2, v); check("R7 after fall", v, 6);
        trig_in = 1'b1;
        cyc(4); rd(2'd2, v); check("R7 second edge", v, 10);
        trig_in = 1'b0;
        cyc(4); rd(2'd2, v); check("R7 continue", v, 14);
        wr(2'd0, ctl(6, 0, 0));
        cyc(3); rd(2'd2, v); check("R7 sw stop", v, 15);
    endtask

    task automatic t_wrap();
        int v;
        wr(2'd0, ctl(0, 1, 0));
        wr(2'd2, 16'd2);
        wr(2'd1, 16'd4);
        wr(2'd0, ctl(0, 1, 1));
        cyc(2); rd(2'd2, v); check("R9 down to 0", v, 0);
        check("R9 no pulse", int'(upd_o), 0);
        cyc(1); rd(2'd2, v); check("R9 down wrap", v, 4);
        check("R9 down pulse", int'(upd_o), 1);
        cyc(1); rd(2'd2, v); check("R9 after wrap", v, 3);
        check("R9 pulse one cycle", int'(upd_o), 0);
        wr(2'd0, ctl(0, 0, 0));
        wr(2'd2, 16'd3);
        wr(2'd0, ctl(0, 0, 1));
        cyc(1); rd(2'd2, v); check("R9 at reload", v, 4);
        check("R9 no early pulse", int'(upd_o), 0);
        cyc(1); rd(2'd2, v); check("R9 up wrap", v, 0);
        check("R9 up pulse", int'(upd_o), 1);
        cyc(1); rd(2'd2, v); check("R8 up step", v, 1);
        check("R9 up pulse end", int'(upd_o), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_modes();
        t_free();
        t_gated();
        t_trig();
        t_wrap();
        finish_run();
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule